// File: doc/BRIEF.md
# PWM Timing Update Controller

The block runs the period counter of a digital pulse width modulator and makes two waveforms, A and B, by comparing the counter against a rising and a falling edge value for each one. The timing it uses sits in a set of active registers. Writes from firmware, and the result of a loop filter that arrives with a done strobe, go into a separate shadow set. An update event copies the shadow set into the active set.

Four event modes are available. The update can follow the filter strobe, the end of each period, the cycle where the counter meets a second sample-trigger value, or both of the last two. Every event opens a recalculation window of a fixed number of cycles, and a flag shows that window. Before a load, a checker rejects any shadow set whose edges or trigger lie beyond the period. An override input turns that check off. The period can come from the local shadow field or from a global period value that several modulators share.

Top module: `pwm_timing_update`

## Requirements
- R1: While reset is low, and in the first cycle after it, the counter reads 0, both waveforms and the window flag are low, and the error flag is clear. The active set holds period DEF_PERIOD with all edges and the trigger at 0.
- R2: The counter counts 0, 1, … up to the active period P and then returns to 0. One PWM period therefore lasts P+1 cycles.
- R3: `pwm_a` is high exactly when A-rise ≤ counter < A-fall. `pwm_b` follows the same rule with the B edges. Both compares use only the active set.
- R4: A write to the shadow set (`wr_addr` 0 = period, 1 = A rise, 2 = A fall, 3 = B rise, 4 = B fall, 5 = trigger-2; 6 and 7 ignored) has no effect on the outputs or on the period until an update event.
- R5: In mode 0 (`upd_sel` = 0) the filter strobe is the update event. `filt_val` replaces the A falling edge and is already part of the set loaded on that same clock edge. This holds in every mode where the strobe falls on an event cycle.
- R6: In mode 1 the only event is the last cycle of a period (counter = P). The new set applies from counter value 0 of the next period.
- R7: In mode 2 the only event is the cycle where the counter equals the active trigger-2 value. The new set applies from the next counter value, in the middle of the period.
- R8: In mode 3 both end of period and the trigger-2 match are events. When they fall on the same cycle, a single update takes place.
- R9: `upd_win` goes high in the cycle after each event and stays high for WIN_CYC cycles. An event inside a running window restarts the count.
- R10: With `chk_ovr` low, a set in which an edge or the trigger exceeds the period is not loaded. The active set is kept and `cfg_err` is set. `cfg_err` stays set until reset.
- R11: With `chk_ovr` high, the shadow set is loaded at every event without any check.
- R12: With `glb_per_en` high, the period loaded at an event is `glb_period` and the local period field is ignored. The check also uses this loaded period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| upd_sel | input | 2 | Update event mode 0..3 |
| chk_ovr | input | 1 | Disables the validity check |
| glb_per_en | input | 1 | Take the period from `glb_period` |
| glb_period | input | CNT_W | Shared global period |
| wr_en | input | 1 | Shadow write strobe |
| wr_addr | input | 3 | Shadow field select |
| wr_data | input | CNT_W | Shadow write value |
| filt_done | input | 1 | Filter result strobe |
| filt_val | input | CNT_W | Filter result (A falling edge) |
| cnt | output | CNT_W | Period counter |
| pwm_a | output | 1 | Waveform A |
| pwm_b | output | 1 | Waveform B |
| upd_win | output | 1 | Recalculation window flag |
| cfg_err | output | 1 | Sticky rejected-set flag |

## Verification
The filter strobe can land on the same cycle as an end-of-period event in mode 1. The end-of-period event and the trigger-2 match can also coincide in mode 3. The bench provokes the first case by waiting until the counter shows the last count and pulsing `filt_done` with a fresh value on that cycle. It then checks the full next period: the A falling edge must already be the strobed value and not the older shadow value. For the second case the trigger is set equal to the period. The bench then checks that the window lasts exactly WIN_CYC cycles and that the counter wraps as normal.

// File: rtl/pwm_upd_pkg.sv
package pwm_upd_pkg;

   typedef enum logic [1:0] {
      UPD_FILT = 2'd0,
      UPD_EOP  = 2'd1,
      UPD_TRIG = 2'd2,
      UPD_BOTH = 2'd3
   } upd_mode_e;

   localparam int NFLD    = 6;
   localparam int F_PER   = 0;
   localparam int F_ARISE = 1;
   localparam int F_AFALL = 2;
   localparam int F_BRISE = 3;
   localparam int F_BFALL = 4;
   localparam int F_TRIG  = 5;
   localparam int ADDR_W  = 3;

endpackage

// File: rtl/pwm_upd_shadow.sv
module pwm_upd_shadow
   import pwm_upd_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter int DEF_PERIOD = 15
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [ADDR_W-1:0]                wr_addr,
   input  logic [CNT_W-1:0]                 wr_data,
   input  logic                             filt_done,
   input  logic [CNT_W-1:0]                 filt_val,
   output logic [NFLD-1:0][CNT_W-1:0]       cand
);

   logic [NFLD-1:0][CNT_W-1:0] shd;

   for (genvar i = 0; i < NFLD; i++) begin : g_fld
      localparam logic [CNT_W-1:0] RST_VAL =
         (i == F_PER) ? CNT_W'(DEF_PERIOD) : '0;

      if (i == F_AFALL) begin : g_filt
         // filter result has priority over a firmware write on the same cycle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               shd[i] <= RST_VAL;
            else if (filt_done)
               shd[i] <= filt_val;
            else if (wr_en && wr_addr == ADDR_W'(i))
               shd[i] <= wr_data;
         end
         assign cand[i] = filt_done ? filt_val : shd[i];
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               shd[i] <= RST_VAL;
            else if (wr_en && wr_addr == ADDR_W'(i))
               shd[i] <= wr_data;
         end
         assign cand[i] = shd[i];
      end
   end

endmodule

// File: rtl/pwm_upd_event.sv
module pwm_upd_event
   import pwm_upd_pkg::*;
#(
   parameter int WIN_CYC = 9
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] upd_sel,
   input  logic       filt_done,
   input  logic       eop,
   input  logic       trig_hit,
   output logic       evt,
   output logic       upd_win
);

   localparam int WW = $clog2(WIN_CYC + 1);

   upd_mode_e  mode;
   logic [WW-1:0] win_cnt;

   assign mode = upd_mode_e'(upd_sel);

   // coincident sources in mode 3 merge into one event
   always_comb begin
      unique case (mode)
         UPD_FILT: evt = filt_done;
         UPD_EOP:  evt = eop;
         UPD_TRIG: evt = trig_hit;
         UPD_BOTH: evt = eop | trig_hit;
         default:  evt = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         win_cnt <= '0;
      else if (evt)
         win_cnt <= WW'(WIN_CYC);
      else if (win_cnt != '0)
         win_cnt <= win_cnt - WW'(1);
   end

   assign upd_win = (win_cnt != '0);

endmodule

// File: rtl/pwm_upd_check.sv
module pwm_upd_check
   import pwm_upd_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic [NFLD-1:0][CNT_W-1:0] cand,
   output logic                       cand_ok
);

   logic [NFLD-1:0] fld_ok;

   for (genvar i = 0; i < NFLD; i++) begin : g_cmp
      if (i == F_PER) begin : g_per
         assign fld_ok[i] = 1'b1;
      end else begin : g_lim
         assign fld_ok[i] = (cand[i] <= cand[F_PER]);
      end
   end

   assign cand_ok = &fld_ok;

endmodule

// File: rtl/pwm_timing_update.sv
module pwm_timing_update
   import pwm_upd_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter int DEF_PERIOD = 15,
   parameter int WIN_CYC    = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        upd_sel,
   input  logic              chk_ovr,
   input  logic              glb_per_en,
   input  logic [CNT_W-1:0]  glb_period,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              filt_done,
   input  logic [CNT_W-1:0]  filt_val,
   output logic [CNT_W-1:0]  cnt,
   output logic              pwm_a,
   output logic              pwm_b,
   output logic              upd_win,
   output logic              cfg_err
);

   localparam int NCH = 2;

   if (CNT_W < 2) begin : g_bad_width
      $error("CNT_W must be at least 2");
   end
   if (WIN_CYC < 1) begin : g_bad_win
      $error("WIN_CYC must be at least 1");
   end
   if (DEF_PERIOD < 1 || DEF_PERIOD >= (1 << CNT_W)) begin : g_bad_per
      $error("DEF_PERIOD out of range for CNT_W");
   end

   logic [NFLD-1:0][CNT_W-1:0] shd_cand;
   logic [NFLD-1:0][CNT_W-1:0] cand;
   logic [NFLD-1:0][CNT_W-1:0] act;
   logic                       cand_ok;
   logic                       evt;
   logic                       eop;
   logic                       trig_hit;
   logic [NCH-1:0]             pwm;

   pwm_upd_shadow #(
      .CNT_W      (CNT_W),
      .DEF_PERIOD (DEF_PERIOD)
   ) u_shadow (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .filt_done (filt_done),
      .filt_val  (filt_val),
      .cand      (shd_cand)
   );

   // period source chosen at load time
   always_comb begin
      cand        = shd_cand;
      cand[F_PER] = glb_per_en ? glb_period : shd_cand[F_PER];
   end

   pwm_upd_check #(
      .CNT_W (CNT_W)
   ) u_check (
      .cand    (cand),
      .cand_ok (cand_ok)
   );

   assign eop      = (cnt >= act[F_PER]);
   assign trig_hit = (cnt == act[F_TRIG]);

   pwm_upd_event #(
      .WIN_CYC (WIN_CYC)
   ) u_event (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd_sel   (upd_sel),
      .filt_done (filt_done),
      .eop       (eop),
      .trig_hit  (trig_hit),
      .evt       (evt),
      .upd_win   (upd_win)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (eop)
         cnt <= '0;
      else
         cnt <= cnt + CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act        <= '0;
         act[F_PER] <= CNT_W'(DEF_PERIOD);
         cfg_err    <= 1'b0;
      end else if (evt) begin
         if (cand_ok || chk_ovr)
            act <= cand;
         else
            cfg_err <= 1'b1;
      end
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam int RI = (c == 0) ? F_ARISE : F_BRISE;
      localparam int FI = (c == 0) ? F_AFALL : F_BFALL;
      assign pwm[c] = (cnt >= act[RI]) && (cnt < act[FI]);
   end

   assign pwm_a = pwm[0];
   assign pwm_b = pwm[1];

endmodule

// File: rtl/pwm_upd_chk.sv
module pwm_upd_chk
   import pwm_upd_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [1:0]                 upd_sel,
   input logic                       chk_ovr,
   input logic [CNT_W-1:0]           cnt,
   input logic [NFLD-1:0][CNT_W-1:0] act,
   input logic [NFLD-1:0][CNT_W-1:0] cand,
   input logic                       cand_ok,
   input logic                       evt,
   input logic                       upd_win,
   input logic                       cfg_err
);

   AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt >= act[F_PER]) |=> (cnt == '0)); // R2

   AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !evt |=> $stable(act)); // R4

   AST_EOP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && upd_sel == 2'd1) |-> (cnt >= act[F_PER])); // R6

   AST_TRIG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && upd_sel == 2'd2) |-> (cnt == act[F_TRIG])); // R7

   AST_WIN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> upd_win); // R9

   AST_REJECT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && !cand_ok && !chk_ovr) |=> ($stable(act) && cfg_err)); // R10

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err); // R10

   AST_OVR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && chk_ovr) |=> (act == $past(cand))); // R11

endmodule

bind pwm_timing_update pwm_upd_chk #(
   .CNT_W (CNT_W)
) u_upd_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .upd_sel (upd_sel),
   .chk_ovr (chk_ovr),
   .cnt     (cnt),
   .act     (act),
   .cand    (cand),
   .cand_ok (cand_ok),
   .evt     (evt),
   .upd_win (upd_win),
   .cfg_err (cfg_err)
);

// File: tb/pwm_timing_update_bench.sv
module pwm_timing_update_bench;

   localparam int CNT_W   = 8;
   localparam int DEF_PER = 15;
   localparam int WIN     = 9;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [1:0]       upd_sel = 2'd0;
   logic             chk_ovr = 1'b0;
   logic             glb_per_en = 1'b0;
   logic [CNT_W-1:0] glb_period = '0;
   logic             wr_en = 1'b0;
   logic [2:0]       wr_addr = '0;
   logic [CNT_W-1:0] wr_data = '0;
   logic             filt_done = 1'b0;
   logic [CNT_W-1:0] filt_val = '0;
   logic [CNT_W-1:0] cnt;
   logic             pwm_a, pwm_b, upd_win, cfg_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pwm_timing_update #(
      .CNT_W      (CNT_W),
      .DEF_PERIOD (DEF_PER),
      .WIN_CYC    (WIN)
   ) u_pwm_timing_update (
      .clk        (clk),
      .rst_n      (rst_n),
      .upd_sel    (upd_sel),
      .chk_ovr    (chk_ovr),
      .glb_per_en (glb_per_en),
      .glb_period (glb_period),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .filt_done  (filt_done),
      .filt_val   (filt_val),
      .cnt        (cnt),
      .pwm_a      (pwm_a),
      .pwm_b      (pwm_b),
      .upd_win    (upd_win),
      .cfg_err    (cfg_err)
   );

   task automatic check(input bit ok, input string tag, input int got, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      wr_en   = 1'b1;
      wr_addr = 3'(a);
      wr_data = CNT_W'(d);
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic pulse_filt(input int v);
      filt_done = 1'b1;
      filt_val  = CNT_W'(v);
      @(negedge clk);
      filt_done = 1'b0;
   endtask

   task automatic wait_cnt(input int v);
      while (cnt != CNT_W'(v)) @(negedge clk);
   endtask

   task automatic next_start();
      while (cnt == '0) @(negedge clk);
      while (cnt != '0) @(negedge clk);
   endtask

   // one full period from counter 0, compared against the edge rule
   task automatic check_wave(input int per, input int ar, input int af,
                             input int br, input int bf, input string tag);
      bit bad = 1'b0;
      int got = 0;
      int exp = 0;
      wait_cnt(0);
      for (int i = 0; i <= per; i++) begin
         bit ea = (i >= ar) && (i < af);
         bit eb = (i >= br) && (i < bf);
         if (!bad && (cnt != CNT_W'(i) || pwm_a != ea || pwm_b != eb)) begin
            bad = 1'b1;
            got = int'(cnt) * 100 + int'(pwm_a) * 10 + int'(pwm_b);
            exp = i * 100 + int'(ea) * 10 + int'(eb);
         end
         @(negedge clk);
      end
      if (!bad && cnt != '0) begin
         bad = 1'b1;
         got = int'(cnt);
         exp = 0;
      end
      check(!bad, tag, got, exp);
   endtask

   task automatic check_window(input string tag);
      bit bad = 1'b0;
      int k_bad = -1;
      for (int k = 0; k < WIN; k++) begin
         if (!bad && !upd_win) begin
            bad = 1'b1;
            k_bad = k;
         end
         @(negedge clk);
      end
      check(!bad, {tag, " window high"}, k_bad, -1);
      check(!upd_win, {tag, " window closes"}, int'(upd_win), 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(cnt == '0, "R1 counter", int'(cnt), 0);
      check(!pwm_a && !pwm_b, "R1 outputs low", int'(pwm_a) + int'(pwm_b), 0);
      check(!upd_win, "R1 window", int'(upd_win), 0);
      check(!cfg_err, "R1 error", int'(cfg_err), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(cnt == 8'd1 && !pwm_a && !pwm_b, "R1 first cycle", int'(cnt), 1);
   endtask

   task automatic t_shadow_hold();
      bit hi = 1'b0;
      bit saw_old_top = 1'b0;
      wr(0, 11); wr(1, 1); wr(2, 5); wr(3, 6); wr(4, 9); wr(5, 4);
      for (int k = 0; k < 20; k++) begin
         if (pwm_a || pwm_b) hi = 1'b1;
         if (cnt == CNT_W'(DEF_PER)) saw_old_top = 1'b1;
         @(negedge clk);
      end
      check(!hi, "R4 outputs unchanged", int'(hi), 0);
      check(saw_old_top, "R4 period unchanged", int'(saw_old_top), 1);
   endtask

   task automatic t_mode_eop();
      upd_sel = 2'd1;
      next_start();
      check_wave(11, 1, 5, 6, 9, "R6 R3 R2 end-of-period load");
   endtask

   task automatic t_window();
      wait_cnt(11);
      @(negedge clk);
      check_window("R9 eop");
   endtask

   task automatic t_mode_trig();
      upd_sel = 2'd0;
      wr(1, 7); wr(2, 10);
      wait_cnt(0);
      upd_sel = 2'd2;
      wait_cnt(3);
      check(pwm_a == 1'b1, "R7 before trigger", int'(pwm_a), 1);
      wait_cnt(8);
      check(pwm_a == 1'b1, "R7 after trigger", int'(pwm_a), 1);
   endtask

   task automatic t_mode_filt();
      upd_sel = 2'd0;
      wait_cnt(2);
      pulse_filt(8);
      check(upd_win == 1'b1, "R9 window after strobe", int'(upd_win), 1);
      wait_cnt(8);
      check(pwm_a == 1'b0, "R5 filter edge applied", int'(pwm_a), 0);
      pulse_filt(8);
      repeat (2) @(negedge clk);
      pulse_filt(8);
      check_window("R9 retrigger");
   endtask

   task automatic t_same_cycle();
      upd_sel = 2'd1;
      wr(1, 2);
      wait_cnt(11);
      pulse_filt(5);
      check_wave(11, 2, 5, 6, 9, "R5 strobe on eop cycle");
   endtask

   task automatic t_mode_both();
      wait_cnt(5);
      upd_sel = 2'd3;
      wr(2, 6);
      wait_cnt(5);
      check(pwm_a == 1'b1, "R8 eop load", int'(pwm_a), 1);
      wait_cnt(1);
      wr(2, 3);
      wait_cnt(5);
      check(pwm_a == 1'b0, "R8 trigger load", int'(pwm_a), 0);
      wr(5, 11);
      wait_cnt(11);
      @(negedge clk);
      wait_cnt(11);
      @(negedge clk);
      check(cnt == '0, "R8 coincident wrap", int'(cnt), 0);
      check_window("R8 coincident single update");
   endtask

   task automatic t_reject();
      upd_sel = 2'd1;
      wr(2, 14);
      next_start();
      check(cfg_err == 1'b1, "R10 error set", int'(cfg_err), 1);
      check_wave(11, 2, 3, 6, 9, "R10 set kept");
      wr(2, 4);
      next_start();
      check(cfg_err == 1'b1, "R10 error sticky", int'(cfg_err), 1);
      check_wave(11, 2, 4, 6, 9, "R10 valid set loads");
   endtask

   task automatic t_override();
      chk_ovr = 1'b1;
      wr(2, 14);
      next_start();
      check_wave(11, 2, 14, 6, 9, "R11 override loads");
      wr(2, 5);
      chk_ovr = 1'b0;
   endtask

   task automatic t_global();
      wr(5, 3);
      glb_period = 8'd9;
      glb_per_en = 1'b1;
      next_start();
      check_wave(9, 2, 5, 6, 9, "R12 global period");
      wr(0, 13);
      next_start();
      check_wave(9, 2, 5, 6, 9, "R12 local ignored");
      glb_per_en = 1'b0;
      next_start();
      check_wave(13, 2, 5, 6, 9, "R12 R2 local period back");
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_shadow_hold();
      t_mode_eop();
      t_window();
      t_mode_trig();
      t_mode_filt();
      t_same_cycle();
      t_mode_both();
      t_reject();
      t_override();
      t_global();
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got %0d expected %0d", 0, 1);
         finish_run();
      end
   end

endmodule